// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns one character at a time into an asynchronous serial frame on a single transmit line. A frame is a low start bit, the data bits least significant first, an optional parity bit and high stop bits. The line rests high between frames. An 8-bit configuration input sets the frame shape: word length, stop length, whether a parity bit is sent, and which parity rule applies (odd, even, forced high or forced low). It also carries a break control that pulls the line low.

Characters arrive through a valid/ready handshake. Timing comes from a one-cycle strobe, `bit_tick`, that pulses `TICKS_PER_BIT` times per bit period, typically 16. The frame shape is captured when a character is accepted, so software can rewrite the configuration at any time without corrupting a frame in flight. The break control is the one exception. It acts on the line at once.

Top module: `serial_frame_tx`

## Requirements
- R1: Bits [1:0] of `frame_cfg` set the word length: 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. The frame starts with one low start bit, followed by `din` bits from bit 0 upward.
- R2: With `frame_cfg[2]`=0 the frame ends in one high stop bit. With `frame_cfg[2]`=1 it ends in 1.5 stop bits at word length 5, and 2 stop bits at any other length. A bit lasts `TICKS_PER_BIT` ticks and a half bit lasts `TICKS_PER_BIT`/2 ticks.
- R3: With `frame_cfg[3]`=0 no parity bit is sent, and the stop bits follow the last data bit directly.
- R4: With `frame_cfg[3]`=1 and `frame_cfg[5:4]`=00, the parity bit makes the count of ones in data plus parity odd. With 01 it makes that count even.
- R5: With `frame_cfg[3]`=1 and `frame_cfg[5:4]`=10, the parity bit is 1. With 11 it is 0.
- R6: While `frame_cfg[6]` is 1, `tx` is 0 whatever the frame state. When the bit clears, `tx` returns to the level the frame state gives.
- R7: After reset `tx` is 1, `busy` is 0 and `din_ready` is 1.
- R8: `din_ready` is the inverse of `busy`. A character is accepted on a cycle where `din_valid` and `din_ready` are both 1, and `busy` rises on the next cycle. `din_valid` is ignored while a frame is in progress.
- R9: The frame shape comes from `frame_cfg[5:0]` as it stands in the accept cycle. Later changes to these bits affect only the next frame.
- R10: The frame advances only on cycles where `bit_tick` is 1. `busy` falls right after the last stop tick, and a frame lasts exactly its computed tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Timing strobe, `TICKS_PER_BIT` per bit period |
| din | input | 8 | Character to send |
| din_valid | input | 1 | `din` holds a character |
| din_ready | output | 1 | Transmitter can take a character |
| frame_cfg | input | 8 | [1:0] length, [2] long stop, [3] parity on, [4] parity sense, [5] forced parity, [6] break, [7] unused |
| tx | output | 1 | Serial line |
| busy | output | 1 | A frame is being sent |

## Verification
The bench builds the transmitter with `TICKS_PER_BIT` = 4 so that a full frame is at most 48 ticks. This makes it cheap to sweep all 64 settings of the six frame-shape bits against several data bytes, covering every length, stop, parity and forced-parity combination, including the half-bit stop at word length 5. The short frame also leaves room for directed frames that rewrite the configuration, raise break and offer new data mid-frame, with every tick of each frame compared against a waveform computed in the bench.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [7:0] din,
  input  logic       din_valid,
  output logic       din_ready,
  input  logic [7:0] frame_cfg,
  output logic       tx,
  output logic       busy
);
  localparam int HALF = TICKS_PER_BIT / 2;
  localparam int CW   = $clog2(2 * TICKS_PER_BIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [2:0]  idx;
  logic [7:0]  dq;
  logic [5:0]  fq;
  logic [CW-1:0] lim;
  logic [CW-1:0] stop_len;
  logic [7:0]  masked;
  logic        par;
  logic        line;
  logic        last_tick;

  always_comb begin
    for (int i = 0; i < 8; i++)
      masked[i] = dq[i] && (i < 5 + int'(fq[1:0]));
  end

  always_comb begin
    case (fq[5:4])
      2'b00:   par = ~^masked;
      2'b01:   par = ^masked;
      2'b10:   par = 1'b1;
      default: par = 1'b0;
    endcase
  end

  always_comb begin
    if (!fq[2])              stop_len = CW'(TICKS_PER_BIT);
    else if (fq[1:0] == 2'b00) stop_len = CW'(TICKS_PER_BIT + HALF);
    else                     stop_len = CW'(2 * TICKS_PER_BIT);
  end

  assign lim       = (st == S_STOP) ? stop_len : CW'(TICKS_PER_BIT);
  assign last_tick = bit_tick && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      dq  <= '0;
      fq  <= '0;
    end else begin
      case (st)
        S_IDLE: if (din_valid) begin
          dq  <= din;
          fq  <= frame_cfg[5:0];
          cnt <= '0;
          st  <= S_START;
        end
        default: if (bit_tick) begin
          if (last_tick) begin
            cnt <= '0;
            case (st)
              S_START: begin
                idx <= '0;
                st  <= S_DATA;
              end
              S_DATA: begin
                if (idx == 3'(4 + int'(fq[1:0])))
                  st <= fq[3] ? S_PAR : S_STOP;
                else
                  idx <= idx + 1'b1;
              end
              S_PAR:   st <= S_STOP;
              default: st <= S_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = dq[idx];
      S_PAR:   line = par;
      default: line = 1'b1;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign din_ready = !busy;
  assign tx        = line && !frame_cfg[6];
endmodule

module serial_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       din_valid,
  input logic       din_ready,
  input logic [7:0] frame_cfg,
  input logic       tx,
  input logic       busy
);
  // R6
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cfg[6] |-> !tx);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid && din_ready |=> busy);

  // R10
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_tick |=> busy);

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !frame_cfg[6] |-> tx);

  // R10
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_tick && !frame_cfg[6] |=> frame_cfg[6] || $stable(tx));
endmodule

bind serial_frame_tx serial_frame_tx_chk chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .din_valid(din_valid),
  .din_ready(din_ready), .frame_cfg(frame_cfg), .tx(tx), .busy(busy)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
  localparam int PERIOD = 10;
  localparam int TPB    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [7:0] din = '0;
  logic       din_valid = 1'b0;
  logic       din_ready;
  logic [7:0] frame_cfg = '0;
  logic       tx;
  logic       busy;

  int checks = 0;
  int errors = 0;
  logic expw [0:63];
  int   nexp;

  serial_frame_tx #(.TICKS_PER_BIT(TPB)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .din(din),
    .din_valid(din_valid), .din_ready(din_ready), .frame_cfg(frame_cfg),
    .tx(tx), .busy(busy)
  );

  always #(PERIOD / 2) clk = ~clk;

  task automatic push(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      expw[nexp] = v;
      nexp++;
    end
  endtask

  task automatic build(input logic [7:0] d, input logic [7:0] c);
    int wl;
    int ones;
    logic p;
    wl = 5 + int'(c[1:0]);
    ones = 0;
    nexp = 0;
    push(1'b0, TPB);
    for (int b = 0; b < wl; b++) begin
      push(d[b], TPB);
      ones += int'(d[b]);
    end
    if (c[3]) begin
      case (c[5:4])
        2'b00:   p = (ones % 2 == 0);
        2'b01:   p = (ones % 2 == 1);
        2'b10:   p = 1'b1;
        default: p = 1'b0;
      endcase
      push(p, TPB);
    end
    if (!c[2])          push(1'b1, TPB);
    else if (wl == 5)   push(1'b1, TPB + TPB / 2);
    else                push(1'b1, 2 * TPB);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One frame: cfg c0 at accept, c1 (bits 5:0) afterwards, break over ticks [bf,bt),
  // junk data offered while busy when junk is set.
  task automatic frame(input logic [7:0] d, input logic [7:0] c0, input logic [7:0] c1,
                       input int bf, input int bt, input bit junk, input string req);
    int bad;
    int first;
    logic got;
    bit rdy_ok;
    build(d, c0);
    @(negedge clk);
    din = d;
    frame_cfg = c0;
    din_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    din_valid = 1'b0;
    frame_cfg = c1 & 8'h3F;
    check(busy && !din_ready && !tx, "R8", {busy, din_ready, tx}, 3'b100);
    bad = 0;
    first = 0;
    got = 1'b0;
    rdy_ok = 1;
    for (int i = 0; i < nexp; i++) begin
      bit_tick = 1'b1;
      frame_cfg[6] = (i >= bf && i < bt);
      din_valid = junk && (i < nexp - 1);
      din = ~d;
      #1;
      if (tx !== (expw[i] && !frame_cfg[6])) begin
        if (bad == 0) begin
          first = i;
          got = tx;
        end
        bad++;
      end
      if (din_ready) rdy_ok = 0;
      @(posedge clk);
      @(negedge clk);
      bit_tick = 1'b0;
      din_valid = 1'b0;
      frame_cfg[6] = 1'b0;
      if (i < nexp - 1 && !busy) rdy_ok = 0;
      @(posedge clk);
      @(negedge clk);
    end
    check(bad == 0, req, int'(got), int'(expw[first]));
    check(!busy && din_ready && tx, "R10", {busy, din_ready, tx}, 3'b011);
    if (junk) check(rdy_ok, "R8", 0, 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx && !busy && din_ready, "R7", {tx, busy, din_ready}, 3'b101);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: no tick means no progress
    din = 8'h5A;
    din_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    din_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(busy && !tx, "R10", {busy, tx}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 in idle
    frame_cfg = 8'h40;
    #1;
    check(!tx, "R6", tx, 0);
    @(negedge clk);
    frame_cfg = 8'h00;
    #1;
    check(tx, "R6", tx, 1);
    // R1 R2 R3 R4 R5: sweep of every frame shape
    for (int c = 0; c < 64; c++) begin
      frame(8'h00, 8'(c), 8'(c), -1, -1, 0, "R1/R2/R3/R4/R5");
      frame(8'hFF, 8'(c), 8'(c), -1, -1, 0, "R1/R2/R3/R4/R5");
      frame(8'hA5, 8'(c), 8'(c), -1, -1, 0, "R1/R2/R3/R4/R5");
      frame(8'(8'h3C + c), 8'(c), 8'(c), -1, -1, 0, "R1/R2/R3/R4/R5");
    end
    // R9: configuration rewritten mid-frame
    frame(8'h96, 8'h0C, 8'h33, -1, -1, 0, "R9");
    frame(8'h69, 8'h3B, 8'h04, -1, -1, 0, "R9");
    // R6: break mid-frame
    frame(8'hFF, 8'h0B, 8'h0B, 6, 15, 0, "R6");
    frame(8'h81, 8'h07, 8'h07, 30, 44, 0, "R6");
    // R8: data offered while busy is ignored
    frame(8'h3E, 8'h1F, 8'h1F, -1, -1, 1, "R8");
    frame(8'hC1, 8'h08, 8'h08, -1, -1, 1, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule